// File: doc/BRIEF.md
# CAN Message Buffer Code State Machine

This block holds the control state of one message buffer of a CAN controller: a 4-bit code, which says what the buffer is doing, and a 4-bit data length. The host writes the code and length as one control byte. The receive side of the protocol engine offers accepted frames to the buffer. The transmit side reports when the frame it was sending has finished. The block moves the code through the receive states and the transmit states, and it raises a one-cycle completion pulse that an interrupt flag can latch.

The receive codes are:

| Code | Meaning |
|------|---------|
| 0x0 | Inactive |
| 0x4 | Empty |
| 0x2 | Full |
| 0x6 | Overrun |

While a frame is being written into the buffer, code bit 0 is set to mark it busy.

The transmit codes are:

| Code | Meaning |
|------|---------|
| 0x8 | Idle |
| 0xC | Send once |
| 0xA | Answer a matching remote request |

A host read of the control byte locks the buffer so that its contents stay coherent. Later frames are then dropped until the host reads the free-running timer. When a buffer sends a remote request, it turns itself into an empty receive buffer so that it can catch the answer.

Top module: `can_mbox_code_fsm`

## Requirements
- R1: After reset the control byte is 0x00, and `locked`, `tx_pend` and `done` are all low.
- R2: The control byte is {code[3:0], dlc[3:0]}, with the code in bits 7:4 and the DLC in bits 3:0. A host write loads both fields in the next cycle. Bit 4 of the write (the busy bit) is ignored and stored as 0. A DLC above MAX_DLC (8) is stored as MAX_DLC.
- R3: When the code is not busy and the buffer is not locked, `rx_start` accepts a frame if the code is 0x4, 0x2 or 0x6. At the end of the fill the code becomes 0x2 if it was 0x4, and 0x6 if it was 0x2 or 0x6. The DLC becomes `rx_dlc`, clamped to MAX_DLC.
- R4: From the cycle after an accepted `rx_start`, code bit 0 is set for exactly BUSY_CYCLES cycles (at most 20). In the following cycle the final code appears and `done` pulses.
- R5: `rx_start` has no effect when the code is 0x0, 0x8, 0xA or 0xC, or while the buffer is busy.
- R6: `host_rd_ctrl` sets `locked` in the next cycle. `host_rd_timer` clears it, and `host_rd_ctrl` wins when both are asserted in the same cycle. While `locked` is high, `rx_start` leaves the control byte unchanged.
- R7: `tx_pend` is high exactly while the code is 0xC. `tx_done` with code 0xC and `tx_was_remote` low sets the code to 0x8 and pulses `done`. `tx_done` with any other code has no effect.
- R8: `tx_done` with code 0xC and `tx_was_remote` high sets the code to 0x4 (empty) and pulses `done`.
- R9: `rx_remote_req` with code 0xA sets the code to 0xC. With any other code it has no effect.
- R10: A host write while the buffer is busy aborts the fill. The written code and DLC take effect, and no `done` pulse follows for the aborted frame.
- R11: `done` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the control byte |
| host_wdata | input | 8 | Control byte written by the host |
| host_rd_ctrl | input | 1 | Host read of the control byte (locks the buffer) |
| host_rd_timer | input | 1 | Host read of the free-running timer (unlocks the buffer) |
| rx_start | input | 1 | Receive side starts writing an accepted frame into this buffer |
| rx_dlc | input | 4 | DLC of the incoming frame |
| rx_remote_req | input | 1 | A remote request matching this buffer was received |
| tx_done | input | 1 | Transmit side finished sending this buffer's frame |
| tx_was_remote | input | 1 | The finished frame was a remote request |
| ctrl_byte | output | 8 | Current {code, dlc} |
| tx_pend | output | 1 | Buffer requests transmission |
| done | output | 1 | One-cycle completion pulse |
| locked | output | 1 | Buffer is locked against new frames |

## Verification
The bench sweeps every written code against an incoming frame and computes which codes accept it and what they become. This catches a design that fills an inactive or transmit buffer, or one that fails to move full to overrun. It sweeps every DLC value through both the host path and the receive path, which catches a missing clamp at 8. It counts the busy cycles exactly and watches the cycle in which `done` rises, so an off-by-one in the fill counter shows up. It also drives the lock/unlock pair, including both reads in the same cycle, the remote-request turnaround to empty, the response code, and a host write in the middle of a fill. A design that drops the lock, forgets to clear the busy bit, or lets an aborted fill raise `done` would fail these checks.

// File: rtl/can_mbox_code_fsm.sv
module can_mbox_code_fsm #(
  parameter int BUSY_CYCLES = 4,
  parameter int MAX_DLC     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd_ctrl,
  input  logic       host_rd_timer,
  input  logic       rx_start,
  input  logic [3:0] rx_dlc,
  input  logic       rx_remote_req,
  input  logic       tx_done,
  input  logic       tx_was_remote,
  output logic [7:0] ctrl_byte,
  output logic       tx_pend,
  output logic       done,
  output logic       locked
);
  localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [3:0] C_EMPTY = 4'h4, C_FULL = 4'h2, C_OVR = 4'h6;
  localparam logic [3:0] C_IDLE = 4'h8, C_SEND = 4'hC, C_ANSW = 4'hA;

  logic [3:0]    code_q, dlc_q;
  logic [CW-1:0] cnt_q;
  logic          lock_q, done_q;

  function automatic logic [3:0] clamp(input logic [3:0] d);
    return (d > 4'(MAX_DLC)) ? 4'(MAX_DLC) : d;
  endfunction

  wire busy      = code_q[0];
  wire rx_ok     = (code_q == C_EMPTY) || (code_q == C_FULL) || (code_q == C_OVR);
  wire rx_accept = rx_start && !lock_q && rx_ok;
  wire [3:0] fill_base  = {code_q[3:1], 1'b0};
  wire [3:0] fill_final = (fill_base == C_EMPTY) ? C_FULL : C_OVR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 4'h0;
      dlc_q  <= 4'h0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (host_wr) begin
        code_q <= {host_wdata[7:5], 1'b0};
        dlc_q  <= clamp(host_wdata[3:0]);
      end else if (busy) begin
        if (cnt_q == '0) begin
          code_q <= fill_final;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (code_q == C_SEND && tx_done) begin
        code_q <= tx_was_remote ? C_EMPTY : C_IDLE;
        done_q <= 1'b1;
      end else if (code_q == C_ANSW && rx_remote_req) begin
        code_q <= C_SEND;
      end else if (rx_accept) begin
        code_q <= code_q | 4'h1;
        dlc_q  <= clamp(rx_dlc);
        cnt_q  <= CW'(BUSY_CYCLES - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lock_q <= 1'b0;
    else if (host_rd_ctrl)  lock_q <= 1'b1;
    else if (host_rd_timer) lock_q <= 1'b0;
  end

  assign ctrl_byte = {code_q, dlc_q};
  assign tx_pend   = (code_q == C_SEND);
  assign done      = done_q;
  assign locked    = lock_q;
endmodule

// File: rtl/can_mbox_code_chk.sv
module can_mbox_code_chk #(
  parameter int BUSY_CYCLES = 4,
  parameter int MAX_DLC     = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       host_rd_ctrl,
  input logic       rx_start,
  input logic       rx_remote_req,
  input logic       tx_done,
  input logic       tx_was_remote,
  input logic [7:0] ctrl_byte,
  input logic       done,
  input logic       locked
);
  localparam int RW = $clog2(BUSY_CYCLES + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (ctrl_byte[4]) run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  p_dlc_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_byte[3:0] <= 4'(MAX_DLC));

  p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(BUSY_CYCLES));

  p_lock_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_ctrl |=> locked);

  p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !ctrl_byte[4] && rx_start && !host_wr && !tx_done && !rx_remote_req)
      |=> $stable(ctrl_byte));

  p_tx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_byte[7:4] == 4'hC && tx_done && !tx_was_remote && !host_wr)
      |=> (ctrl_byte[7:4] == 4'h8 && done));

  p_remote_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_byte[7:4] == 4'hC && tx_done && tx_was_remote && !host_wr)
      |=> (ctrl_byte[7:4] == 4'h4 && done));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata[7:4] == 4'h0) |=> (ctrl_byte[7:4] == 4'h0 && !done));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind can_mbox_code_fsm can_mbox_code_chk #(.BUSY_CYCLES(BUSY_CYCLES), .MAX_DLC(MAX_DLC)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rd_ctrl(host_rd_ctrl), .rx_start(rx_start), .rx_remote_req(rx_remote_req),
  .tx_done(tx_done), .tx_was_remote(tx_was_remote), .ctrl_byte(ctrl_byte),
  .done(done), .locked(locked)
);

// File: tb/test_can_mbox_code_fsm.sv
module test_can_mbox_code_fsm;
  localparam int BUSY = 4;
  localparam int MAXD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd_ctrl = 0, host_rd_timer = 0;
  logic rx_start = 0, rx_remote_req = 0, tx_done = 0, tx_was_remote = 0;
  logic [7:0] host_wdata = 0;
  logic [3:0] rx_dlc = 0;
  logic [7:0] ctrl_byte;
  logic tx_pend, done, locked;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  can_mbox_code_fsm #(.BUSY_CYCLES(BUSY), .MAX_DLC(MAXD)) i_can_mbox_code_fsm (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd_ctrl(host_rd_ctrl), .host_rd_timer(host_rd_timer),
    .rx_start(rx_start), .rx_dlc(rx_dlc), .rx_remote_req(rx_remote_req),
    .tx_done(tx_done), .tx_was_remote(tx_was_remote),
    .ctrl_byte(ctrl_byte), .tx_pend(tx_pend), .done(done), .locked(locked));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int clampd(input int d);
    return (d > MAXD) ? MAXD : d;
  endfunction

  task automatic wr(input logic [7:0] b);
    @(negedge clk); host_wr = 1; host_wdata = b;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rx(input logic [3:0] d);
    @(negedge clk); rx_start = 1; rx_dlc = d;
    @(negedge clk); rx_start = 0;
  endtask

  task automatic txd(input logic rem);
    @(negedge clk); tx_done = 1; tx_was_remote = rem;
    @(negedge clk); tx_done = 0; tx_was_remote = 0;
  endtask

  task automatic rreq();
    @(negedge clk); rx_remote_req = 1;
    @(negedge clk); rx_remote_req = 0;
  endtask

  task automatic rd(input logic c, input logic t);
    @(negedge clk); host_rd_ctrl = c; host_rd_timer = t;
    @(negedge clk); host_rd_ctrl = 0; host_rd_timer = 0;
  endtask

  task automatic fill_finish(input int fin);
    for (int k = 1; k < BUSY; k++) begin
      chk("R4 busy", ctrl_byte[4], 1);
      @(negedge clk);
    end
    chk("R4 busy last", ctrl_byte[4], 1);
    @(negedge clk);
    chk("R3 final code", ctrl_byte[7:4], fin);
    chk("R4 done", done, 1);
    @(negedge clk);
    chk("R11 done single", done, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl", ctrl_byte, 0);
    chk("R1 locked", locked, 0);
    chk("R1 tx_pend", tx_pend, 0);
    chk("R1 done", done, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: DLC clamp and busy bit ignored on host write
    for (int d = 0; d < 16; d++) begin
      wr(8'h10 | 8'(d));
      chk("R2 code", ctrl_byte[7:4], 0);
      chk("R2 dlc", ctrl_byte[3:0], clampd(d));
    end

    // R3/R5: sweep all written codes against an incoming frame
    for (int c = 0; c < 16; c++) begin
      int w;
      bit acc;
      w = c & 14;
      acc = (w == 4) || (w == 2) || (w == 6);
      wr(8'((c << 4) | 3));
      chk("R7 tx_pend", tx_pend, (w == 12) ? 1 : 0);
      rx(4'd5);
      if (acc) begin
        chk("R3 dlc", ctrl_byte[3:0], 5);
        fill_finish((w == 4) ? 2 : 6);
      end else begin
        chk("R5 ignored code", ctrl_byte[7:4], w);
        chk("R5 ignored dlc", ctrl_byte[3:0], 3);
        chk("R5 no done", done, 0);
      end
    end

    // R3: received DLC clamp sweep
    for (int d = 0; d < 16; d++) begin
      wr(8'h40);
      rx(4'(d));
      chk("R3 rx dlc", ctrl_byte[3:0], clampd(d));
      fill_finish(2);
    end

    // R5: frame during busy is ignored
    wr(8'h40);
    rx(4'd2);
    rx(4'd7);
    chk("R5 busy dlc kept", ctrl_byte[3:0], 2);
    for (int k = 0; k < BUSY + 1; k++) @(negedge clk);
    chk("R5 busy ends full", ctrl_byte[7:4], 2);

    // R6: lock and unlock
    wr(8'h40);
    rd(1, 0);
    chk("R6 locked", locked, 1);
    rx(4'd6);
    chk("R6 dropped code", ctrl_byte[7:4], 4);
    chk("R6 dropped dlc", ctrl_byte[3:0], 0);
    rd(1, 1);
    chk("R6 both reads", locked, 1);
    rd(0, 1);
    chk("R6 unlocked", locked, 0);
    rx(4'd6);
    fill_finish(2);

    // R7: transmit once
    wr(8'hC8);
    chk("R7 pend", tx_pend, 1);
    txd(0);
    chk("R7 idle", ctrl_byte[7:4], 8);
    chk("R7 done", done, 1);
    chk("R7 pend clr", tx_pend, 0);
    txd(0);
    chk("R7 ignored", ctrl_byte[7:4], 8);
    chk("R7 no done", done, 0);

    // R8: remote request sent -> empty receive
    wr(8'hC0);
    txd(1);
    chk("R8 empty", ctrl_byte[7:4], 4);
    chk("R8 done", done, 1);
    rx(4'd8);
    fill_finish(2);

    // R9: response buffer
    wr(8'hA4);
    txd(0);
    chk("R7 ignored on A", ctrl_byte[7:4], 4'hA);
    rreq();
    chk("R9 to send", ctrl_byte[7:4], 4'hC);
    chk("R9 pend", tx_pend, 1);
    wr(8'h80);
    rreq();
    chk("R9 ignored", ctrl_byte[7:4], 8);

    // R10: abort in mid-fill
    wr(8'h40);
    rx(4'd3);
    wr(8'h07);
    chk("R10 code", ctrl_byte[7:4], 0);
    chk("R10 dlc", ctrl_byte[3:0], 7);
    for (int k = 0; k < BUSY + 2; k++) begin
      chk("R10 no done", done, 0);
      @(negedge clk);
    end
    chk("R10 stays", ctrl_byte, 8'h07);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule